// File: doc/BRIEF.md
# I2C Rheostat Command Slave

This block is the serial front end of a digitally set resistor. It watches a two-wire I2C bus, with clock and data sampled in the system clock domain. It answers to one 7-bit address. Five high bits of that address are fixed, and the two low bits come from a strap pin that can be tied low, tied high or left open. Each write carries 16-bit words, most significant bit first, in two bytes. The block splits every received word into a 4-bit command and a 10-bit data field. It hands the pair to the register core on a single-cycle strobe.

A read returns a 16-bit word supplied by the core, high byte first. It repeats the word for as long as the master acknowledges, and it lets go of the bus at the master's first no-acknowledge. While the storage controller reports busy, the slave acknowledges nothing, not even its own address. A master can therefore poll the address acknowledge to learn when a store has finished. A resolution parameter selects the 8-bit variant, in which the two lowest data bits are forced to zero in both directions.

Top module: `i2c_rheo_slave`

## Requirements
- R1: The slave acknowledges the address 01011 followed by two strap bits. The strap code is 2'b00 for tied low, which gives low bits 11. It is 2'b01 for tied high, which gives 00. It is 2'b10 for open, which gives 10, and 2'b11 is treated as open.
- R2: The slave does not acknowledge any other address, including general call 0000000 and the 10-bit prefix 11110xx. The bytes that follow are ignored and no strobe is produced.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop, or a repeated start, in mid-word discards the partial word and releases SDA.
- R4: In a write, each data byte is acknowledged by pulling SDA low during the ninth SCL pulse. After the second byte's acknowledge, cmd_valid_o pulses for exactly one clock. With that pulse, cmd_o carries word bits 13:10 and data_o carries word bits 9:0.
- R5: With RES_BITS=8, data_o[1:0] is zero on every strobe, and bits 1:0 of the read word are sent as zero.
- R6: While busy_i is high, neither the address nor any data byte is acknowledged. A write that is refused this way produces no strobe.
- R7: In a read, the slave drives rd_word_i MSB first and changes SDA only while SCL is low. It repeats the word while the master acknowledges. After a master no-acknowledge, it leaves SDA released until the next start.
- R8: While reset is asserted, and after it, sda_oe_o and cmd_valid_o are low.
- R9: A pulse on SCL or SDA one clock wide is filtered out and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| strap_i | input | 2 | Address strap state: 00 low, 01 high, 10 or 11 open |
| busy_i | input | 1 | Storage in progress; all acknowledges are withheld |
| rd_word_i | input | 16 | Word returned on reads |
| cmd_valid_o | output | 1 | One-clock strobe for a complete word |
| cmd_o | output | 4 | Command field of the word |
| data_o | output | 10 | Data field of the word |

## Verification
Write transactions are run under each of the three strap states. The resulting acknowledges separate a correct address match from a design that ignores the strap or decodes it wrongly. Non-matching addresses are sent, among them general call, a neighbour address and a 10-bit prefix, to show that the match is exact. Busy is raised in two places, before the address and between the two data bytes, which tests both acknowledge points. Partial words are cut off by a stop and by a repeated start, a read is ended by a no-acknowledge, and a one-clock SCL glitch is injected inside a byte, which separates correct word framing from framing that miscounts bits or leaks partial words.

// File: rtl/i2c_rheo_pkg.sv
package i2c_rheo_pkg;
  localparam logic [4:0] ADDR_PREFIX = 5'b01011;

  localparam logic [1:0] STRAP_LOW  = 2'b00;
  localparam logic [1:0] STRAP_HIGH = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_line_filt.sv
module i2c_line_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // output moves only when all recent samples agree
      if (&hist_q)       line_o <= 1'b1;
      else if (~|hist_q) line_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_rheo_pkg::*;
(
  input  logic [1:0] strap_i,
  input  logic [6:0] addr_i,
  output logic       hit_o
);
  logic [1:0] low_bits;

  always_comb begin
    unique case (strap_i)
      STRAP_LOW:  low_bits = 2'b11;
      STRAP_HIGH: low_bits = 2'b00;
      default:    low_bits = 2'b10;
    endcase
  end

  assign hit_o = (addr_i == {ADDR_PREFIX, low_bits});
endmodule

// File: rtl/i2c_rheo_slave.sv
module i2c_rheo_slave
  import i2c_rheo_pkg::*;
#(
  parameter int CMD_W       = 4,
  parameter int DATA_W      = 10,
  parameter int RES_BITS    = 10,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic [1:0]              strap_i,
  input  logic                    busy_i,
  input  logic [15:0]             rd_word_i,
  output logic                    cmd_valid_o,
  output logic [CMD_W-1:0]        cmd_o,
  output logic [DATA_W-1:0]       data_o
);
  localparam int FIELD_W = CMD_W + DATA_W;
  localparam int HI_W    = FIELD_W - 8;
  localparam int DROP    = DATA_W - RES_BITS;

  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_e, stop_e;
  logic addr_hit;
  logic [15:0] rd_word_m;

  bus_st_e            st_q;
  logic [3:0]         bit_cnt_q;
  logic [7:0]         sh_q;
  logic [HI_W-1:0]    hi_q;
  logic [FIELD_W-1:0] word_q;
  logic [15:0]        tx_q;
  logic               byte_sel_q, rw_q, mack_q;
  logic               sda_oe_q, valid_q;
  logic               ack_drv;

  i2c_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk_i, .rst_ni, .line_i(scl_i), .line_o(scl_f)
  );
  i2c_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk_i, .rst_ni, .line_i(sda_i), .line_o(sda_f)
  );

  i2c_bus_events u_events (
    .clk_i, .rst_ni, .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_e), .stop_o(stop_e)
  );

  i2c_addr_match u_match (
    .strap_i, .addr_i(sh_q[7:1]), .hit_o(addr_hit)
  );

  generate
    if (DROP > 0) begin : g_lowres
      assign rd_word_m = {rd_word_i[15:DROP], {DROP{1'b0}}};
      assign data_o    = {word_q[DATA_W-1:DROP], {DROP{1'b0}}};
    end else begin : g_fullres
      assign rd_word_m = rd_word_i;
      assign data_o    = word_q[DATA_W-1:0];
    end
  endgenerate

  assign cmd_o       = word_q[FIELD_W-1:DATA_W];
  assign cmd_valid_o = valid_q;
  assign sda_oe_o    = sda_oe_q;
  assign ack_drv     = (st_q == ST_ADDR_ACK) || (st_q == ST_WR_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      hi_q       <= '0;
      word_q     <= '0;
      tx_q       <= '0;
      byte_sel_q <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_e) begin
        st_q       <= ST_ADDR;
        bit_cnt_q  <= '0;
        byte_sel_q <= 1'b0;
        sda_oe_q   <= 1'b0;
      end else if (stop_e) begin
        st_q       <= ST_IDLE;
        byte_sel_q <= 1'b0;
        sda_oe_q   <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q      <= {sh_q[6:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (addr_hit && !busy_i) begin
                sda_oe_q <= 1'b1;
                rw_q     <= sh_q[0];
                st_q     <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt_q  <= '0;
              byte_sel_q <= 1'b0;
              if (rw_q) begin
                tx_q     <= rd_word_m;
                sda_oe_q <= !rd_word_m[15];
                st_q     <= ST_RD;
              end else begin
                sda_oe_q <= 1'b0;
                st_q     <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh_q      <= {sh_q[6:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (busy_i) begin
                byte_sel_q <= 1'b0;
                st_q       <= ST_SKIP;
              end else begin
                sda_oe_q <= 1'b1;
                st_q     <= ST_WR_ACK;
                if (!byte_sel_q) hi_q <= sh_q[HI_W-1:0];
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe_q   <= 1'b0;
              bit_cnt_q  <= '0;
              st_q       <= ST_WR;
              byte_sel_q <= !byte_sel_q;
              if (byte_sel_q) begin
                valid_q <= 1'b1;
                word_q  <= {hi_q, sh_q};
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
              tx_q      <= {tx_q[14:0], 1'b0};
              if (bit_cnt_q == 4'd7) begin
                sda_oe_q <= 1'b0;
                st_q     <= ST_RD_ACK;
              end else begin
                sda_oe_q <= !tx_q[14];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= !sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                bit_cnt_q  <= '0;
                byte_sel_q <= !byte_sel_q;
                st_q       <= ST_RD;
                if (byte_sel_q) begin
                  tx_q     <= rd_word_m;
                  sda_oe_q <= !rd_word_m[15];
                end else begin
                  sda_oe_q <= !tx_q[15];
                end
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rheo_slave_chk.sv
module i2c_rheo_slave_chk #(
  parameter int DATA_W   = 10,
  parameter int RES_BITS = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              sda_oe_o,
  input logic              cmd_valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic              ack_drv,
  input logic              scl_f,
  input logic              stop_e
);
  localparam int DROP = DATA_W - RES_BITS;
  localparam logic [DATA_W-1:0] LOW_M = DATA_W'((1 << DROP) - 1);

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_idle_r8: assert (!sda_oe_o && !cmd_valid_o);
  end

  p_strobe_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_strobe_lowbits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ((data_o & LOW_M) == '0));

  p_busy_noack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> !$rose(ack_drv));

  p_stop_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_e |=> !sda_oe_o);

  p_drive_scl_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_f);
endmodule

bind i2c_rheo_slave i2c_rheo_slave_chk #(.DATA_W(DATA_W), .RES_BITS(RES_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .sda_oe_o(sda_oe_o),
  .cmd_valid_o(cmd_valid_o), .data_o(data_o), .ack_drv(ack_drv),
  .scl_f(scl_f), .stop_e(stop_e)
);

// File: tb/sim_i2c_rheo_slave.sv
module sim_i2c_rheo_slave;
  localparam int HP = 20;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0, glitch_req = 1'b0;
  logic busy = 1'b0;
  logic [1:0] strap = 2'b00;
  logic [15:0] rd_word = 16'h2A5F;
  logic sda_oe, cmd_valid;
  logic [3:0] cmd;
  logic [9:0] data;

  wire scl_line = m_scl ^ glitch;
  wire sda_line = m_sda & ~sda_oe;

  int n_run = 0, n_fail = 0;
  logic [13:0] exp_q[$];
  bit done = 1'b0;

  i2c_rheo_slave #(.RES_BITS(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .busy_i(busy), .rd_word_i(rd_word),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .data_o(data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] own_addr(input logic [1:0] s);
    case (s)
      2'b00:   return 7'b0101111;
      2'b01:   return 7'b0101100;
      default: return 7'b0101110;
    endcase
  endfunction

  task automatic put_bit(input bit b);
    m_sda = b;
    tick(Q / 2);
    if (glitch_req) begin  // R9 one-clock SCL pulse inside low phase
      glitch = 1'b1; tick(1); glitch = 1'b0; glitch_req = 1'b0;
      tick(Q / 2 - 1);
    end else tick(Q / 2);
    m_scl = 1'b1; tick(HP); m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(HP / 2);
    b = sda_line;
    tick(HP / 2); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!mack);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  function automatic logic [13:0] exp_field(input logic [7:0] b1, input logic [7:0] b0);
    logic [15:0] w;
    w = {b1, b0};
    return {w[13:10], w[9:2], 2'b00};
  endfunction

  // full write of one word; expect acks only if address matches and not busy
  task automatic wr_word(input logic [6:0] a, input logic [7:0] b1, input logic [7:0] b0,
                         input bit exp_ack, input string req);
    bit ack;
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk(ack == exp_ack, {req, " address ack"}, ack, exp_ack);
    if (exp_ack) exp_q.push_back(exp_field(b1, b0));
    send_byte(b1, ack);
    chk(ack == exp_ack, {req, " byte1 ack"}, ack, exp_ack);
    send_byte(b0, ack);
    chk(ack == exp_ack, {req, " byte0 ack"}, ack, exp_ack);
    bus_stop();
    tick(5);
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected strobe", {cmd, data}, 0);
      end else begin
        logic [13:0] w;
        w = exp_q.pop_front();
        chk({cmd, data} == w, "R4 word fields", {cmd, data}, w);
        chk(data[1:0] == 2'b00, "R5 low data bits", data[1:0], 0);
      end
    end
  end

  initial begin
    tick(180000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    tick(3);
    chk(sda_oe == 1'b0, "R8 reset sda_oe", sda_oe, 0);
    chk(cmd_valid == 1'b0, "R8 reset strobe", cmd_valid, 0);
    rst_n = 1'b1;
    tick(10);
    chk(sda_oe == 1'b0 && cmd_valid == 1'b0, "R8 after reset idle", sda_oe, 0);

    // R1 each strap state
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      wr_word(own_addr(strap), 8'h15, 8'hA7 ^ 8'(s), 1'b1, "R1 strap");
    end
    strap = 2'b01;
    wr_word(7'b0101111, 8'h3F, 8'hFF, 1'b0, "R1 wrong strap");

    // R2 foreign addresses
    wr_word(7'b0000000, 8'h12, 8'h34, 1'b0, "R2 general call");
    wr_word(7'b1111000, 8'h12, 8'h34, 1'b0, "R2 ten-bit prefix");
    wr_word(7'b0101101, 8'h12, 8'h34, 1'b0, "R2 neighbour");

    // R4 patterns
    wr_word(own_addr(strap), 8'h00, 8'h00, 1'b1, "R4 zeros");
    wr_word(own_addr(strap), 8'h3C, 8'h03, 1'b1, "R4 mixed");

    // R3 partial word ended by stop
    bus_start();
    send_byte({own_addr(strap), 1'b0}, ack);
    chk(ack, "R3 address ack", ack, 1);
    send_byte(8'h2B, ack);
    chk(ack, "R3 first byte ack", ack, 1);
    bus_stop();
    tick(5);
    chk(sda_oe == 1'b0, "R3 release on stop", sda_oe, 0);

    // R3 partial word then repeated start and a full word
    bus_start();
    send_byte({own_addr(strap), 1'b0}, ack);
    send_byte(8'h11, ack);
    bus_start();
    send_byte({own_addr(strap), 1'b0}, ack);
    chk(ack, "R3 repeated start address ack", ack, 1);
    exp_q.push_back(exp_field(8'h06, 8'h5A));
    send_byte(8'h06, ack);
    send_byte(8'h5A, ack);
    chk(ack, "R3 byte after repeated start", ack, 1);
    bus_stop();
    tick(5);

    // R6 busy before address
    busy = 1'b1;
    wr_word(own_addr(strap), 8'h01, 8'h02, 1'b0, "R6 busy address");
    // R6 busy raised between bytes
    busy = 1'b0;
    bus_start();
    send_byte({own_addr(strap), 1'b0}, ack);
    send_byte(8'h07, ack);
    chk(ack, "R6 first byte ack when idle", ack, 1);
    busy = 1'b1;
    send_byte(8'h08, ack);
    chk(!ack, "R6 second byte no ack while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    tick(5);

    // R9 glitch inside a data byte
    glitch_req = 1'b1;
    wr_word(own_addr(strap), 8'h29, 8'hC6, 1'b1, "R9 glitch");

    // R7 read, word repeats, NACK releases
    strap = 2'b10;
    bus_start();
    send_byte({own_addr(strap), 1'b1}, ack);
    chk(ack, "R7 read address ack", ack, 1);
    recv_byte(v, 1'b1);
    chk(v == 8'h2A, "R7 read high byte", v, 8'h2A);
    recv_byte(v, 1'b1);
    chk(v == 8'h5C, "R5 read low byte masked", v, 8'h5C);
    recv_byte(v, 1'b0);
    chk(v == 8'h2A, "R7 read word repeats", v, 8'h2A);
    tick(Q);
    chk(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
    recv_byte(v, 1'b0);
    chk(v == 8'hFF, "R7 released bus reads high", v, 8'hFF);
    bus_stop();
    tick(20);

    chk(exp_q.size() == 0, "R4 missing strobes", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule